// File: doc/BRIEF.md
# Flash Toggle-Bit Completion Poller

This block sits on the host side of a parallel NOR flash and decides when an embedded program or erase operation inside the device has finished. A one-cycle start pulse makes it issue read cycles on an 8-bit data bus in pairs. In each pair it compares one status bit, the toggle bit, between the two reads. The device flips this bit on every read while it is busy and holds it steady once it is idle. If the bit toggles, the poller looks at the timing-limit failure flag (bit 5) of the later read. When that flag is set, the poller does not judge the outcome from that pair. It reads a fresh pair, because the toggling may have stopped at the same moment the flag rose.

The poller reports the outcome with a one-cycle done pulse and two levels: fail, and timeout. Timeout comes from a programmable cap on the number of toggling pairs in which the failure flag was clear. After any failure the poller writes the reset command (0xF0) once, which returns the device to array reads. Its bus port is a plain request/acknowledge port for reads and writes. A host that no longer wants to wait can abort polling, and the next start then begins the algorithm from the first pair.

Top module: `toggle_status_poller`

## Requirements
- R1: After reset, busy, done, fail, timeout and bus_req are all low.
- R2: A start pulse in idle begins polling: bus_req goes high with bus_we low, and each read completes in a cycle where bus_ack is high, with bus_rdata sampled in that cycle. A start pulse while busy has no effect on the sequence or its outcome.
- R3: When the toggle bit has the same value in both reads of a pair, the poller ends with a one-cycle done pulse, fail=0, timeout=0 and no write. busy is low in the cycle that done is high.
- R4: When the toggle bit differs within a pair and bit 5 of the second read is 0, another pair is read. Bit 5 of the first read of the pair has no effect.
- R5: When the toggle bit differs within a pair and bit 5 of the second read is 1, a recheck pair is read. If the toggle bit is equal in the recheck pair, the outcome is success.
- R6: When the toggle bit still differs in the recheck pair, the outcome is fail=1 with timeout=0, whatever bit 5 of the recheck reads holds.
- R7: The toggle bit is data bit 6 when use_alt_bit is 0 and data bit 2 when it is 1. The setting is captured at start.
- R8: Toggling pairs with bit 5 clear are counted. When the count reaches max_pairs, or 1 when max_pairs is 0, the outcome is fail=1 and timeout=1. Pairs with bit 5 set are not counted. max_pairs is captured at start.
- R9: After any failure, one write is requested with bus_we=1 and bus_wdata=0xF0. busy stays high and done stays low until that write is acknowledged. The done pulse then follows.
- R10: abort, while reads are in progress, drops bus_req and returns the poller to idle in the next cycle without a done pulse. The next start begins with a fresh first pair, with both the recheck state and the pair count cleared.
- R11: fail and timeout keep their values after done until the next start, which clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start pulse; accepted only when idle |
| abort | input | 1 | Abandon polling during the read phase |
| use_alt_bit | input | 1 | 0: toggle bit is bit 6; 1: toggle bit is bit 2 |
| max_pairs | input | CNT_W | Cap on counted toggling pairs (0 acts as 1) |
| bus_req | output | 1 | Bus request, held until bus_ack |
| bus_we | output | 1 | 1 for the reset-command write, 0 for reads |
| bus_wdata | output | 8 | Write data (0xF0 during the write) |
| bus_ack | input | 1 | Completes the current bus transfer |
| bus_rdata | input | 8 | Read data, valid when bus_ack is high |
| busy | output | 1 | High from start acceptance until done or abort |
| done | output | 1 | One-cycle completion pulse |
| fail | output | 1 | Outcome failed; held until next start |
| timeout | output | 1 | Failure came from the pair cap; held until next start |

## Verification
The bench builds the poller with CNT_W=4, so the cap covers 0 to 15. This puts the zero-means-one case and caps of 1 to 3 within a few read pairs. With those small caps, the bench can tell apart a cap reached by counted pairs from a recheck pair that must not be counted. The acknowledge of the reset write is also held back for several cycles to expose the hold of busy. Aborts are placed right after the recheck decision and right after two counted pairs, so that leftover recheck or count state would change the outcome of the next run.

// File: rtl/flash_poll_pkg.sv
package flash_poll_pkg;

    localparam int DATA_W = 8;
    localparam int FAIL_BIT = 5;
    localparam int MAIN_TGL_BIT = 6;
    localparam int ALT_TGL_BIT = 2;
    localparam logic [DATA_W-1:0] RESET_CMD = 8'hF0;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RD_A,
        ST_RD_B,
        ST_RST_WR
    } poll_state_e;

    typedef struct packed {
        logic fail;
        logic timeout;
    } poll_result_t;

    typedef struct packed {
        logic              req;
        logic              we;
        logic [DATA_W-1:0] wdata;
    } bus_cmd_t;

    function automatic logic pick_toggle(input logic [DATA_W-1:0] d, input logic alt);
        return d[alt ? ALT_TGL_BIT : MAIN_TGL_BIT];
    endfunction

endpackage

// File: rtl/toggle_sampler.sv
module toggle_sampler
    import flash_poll_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              capture,
    input  logic              use_alt,
    input  logic [DATA_W-1:0] rdata,
    output logic              toggled,
    output logic              fail_flag
);

    logic first_q;

    // Toggle bit of the first read of a pair is held for the second read.
    always_ff @(posedge clk) begin
        if (rst) begin
            first_q <= 1'b0;
        end else if (capture) begin
            first_q <= pick_toggle(rdata, use_alt);
        end
    end

    assign toggled   = first_q ^ pick_toggle(rdata, use_alt);
    assign fail_flag = rdata[FAIL_BIT];

endmodule

// File: rtl/pair_limit.sv
module pair_limit #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             inc,
    input  logic [CNT_W-1:0] max_pairs,
    output logic             limit_hit
);

    localparam int EXT_W = CNT_W + 1;

    logic [CNT_W-1:0] cnt_q;
    logic [EXT_W-1:0] next_cnt;
    logic [EXT_W-1:0] limit;

    assign next_cnt  = {1'b0, cnt_q} + EXT_W'(1);
    assign limit     = (max_pairs == '0) ? EXT_W'(1) : {1'b0, max_pairs};
    assign limit_hit = (next_cnt >= limit);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt_q <= '0;
        end else if (inc) begin
            cnt_q <= next_cnt[CNT_W-1:0];
        end
    end

    // R8: the count never runs past the cap, since reaching it ends polling
    a_r8_count_bound: assert property (@(posedge clk) disable iff (rst)
        ({1'b0, cnt_q} <= limit));

endmodule

// File: rtl/poll_fsm.sv
module poll_fsm
    import flash_poll_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic         abort,
    input  logic         bus_ack,
    input  logic         toggled,
    input  logic         fail_flag,
    input  logic         limit_hit,
    output bus_cmd_t     cmd,
    output logic         capture,
    output logic         launch,
    output logic         cnt_inc,
    output logic         busy,
    output logic         done,
    output poll_result_t result
);

    poll_state_e  state_q, state_d;
    logic         recheck_q, recheck_d;
    poll_result_t res_q, res_d;
    logic         done_q, done_d;

    always_comb begin
        state_d   = state_q;
        recheck_d = recheck_q;
        res_d     = res_q;
        done_d    = 1'b0;
        capture   = 1'b0;
        launch    = 1'b0;
        cnt_inc   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    launch    = 1'b1;
                    recheck_d = 1'b0;
                    res_d     = '0;
                    state_d   = ST_RD_A;
                end
            end
            ST_RD_A: begin
                if (abort) begin
                    recheck_d = 1'b0;
                    state_d   = ST_IDLE;
                end else if (bus_ack) begin
                    capture = 1'b1;
                    state_d = ST_RD_B;
                end
            end
            ST_RD_B: begin
                if (abort) begin
                    recheck_d = 1'b0;
                    state_d   = ST_IDLE;
                end else if (bus_ack) begin
                    if (!toggled) begin
                        done_d  = 1'b1;
                        state_d = ST_IDLE;
                    end else if (recheck_q) begin
                        res_d.fail = 1'b1;
                        state_d    = ST_RST_WR;
                    end else if (fail_flag) begin
                        recheck_d = 1'b1;
                        state_d   = ST_RD_A;
                    end else begin
                        cnt_inc = 1'b1;
                        if (limit_hit) begin
                            res_d.fail    = 1'b1;
                            res_d.timeout = 1'b1;
                            state_d       = ST_RST_WR;
                        end else begin
                            state_d = ST_RD_A;
                        end
                    end
                end
            end
            ST_RST_WR: begin
                if (bus_ack) begin
                    done_d  = 1'b1;
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            recheck_q <= 1'b0;
            res_q     <= '0;
            done_q    <= 1'b0;
        end else begin
            state_q   <= state_d;
            recheck_q <= recheck_d;
            res_q     <= res_d;
            done_q    <= done_d;
        end
    end

    assign cmd.req   = (state_q != ST_IDLE);
    assign cmd.we    = (state_q == ST_RST_WR);
    assign cmd.wdata = (state_q == ST_RST_WR) ? RESET_CMD : '0;
    assign busy      = (state_q != ST_IDLE);
    assign done      = done_q;
    assign result    = res_q;

    // R3: done lasts exactly one cycle
    a_r3_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done_q |=> !done_q);

    // R2: a read request is held until acknowledged or aborted
    a_r2_req_hold: assert property (@(posedge clk) disable iff (rst)
        (cmd.req && !cmd.we && !bus_ack && !abort) |=> cmd.req);

    // R9: the reset write stays pending, and busy stays high, until its acknowledge
    a_r9_write_hold: assert property (@(posedge clk) disable iff (rst)
        (cmd.we && !bus_ack) |=> (busy && cmd.we && !done_q));

    // R6: fail only rises on the way into the reset write
    a_r6_fail_then_write: assert property (@(posedge clk) disable iff (rst)
        $rose(res_q.fail) |-> (state_q == ST_RST_WR));

    // R8: timeout never stands without fail
    a_r8_timeout_is_fail: assert property (@(posedge clk) disable iff (rst)
        res_q.timeout |-> res_q.fail);

    // R10: abort during reads returns to idle with no done
    a_r10_abort_idle: assert property (@(posedge clk) disable iff (rst)
        (busy && !cmd.we && abort) |=> (!busy && !done_q));

endmodule

// File: rtl/toggle_status_poller.sv
module toggle_status_poller
    import flash_poll_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              abort,
    input  logic              use_alt_bit,
    input  logic [CNT_W-1:0]  max_pairs,
    output logic              bus_req,
    output logic              bus_we,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_ack,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic              busy,
    output logic              done,
    output logic              fail,
    output logic              timeout
);

    bus_cmd_t         cmd;
    poll_result_t     result;
    logic             capture, launch, cnt_inc;
    logic             toggled, fail_flag, limit_hit;
    logic             alt_q;
    logic [CNT_W-1:0] max_q;

    // Configuration is frozen for the whole polling run
    always_ff @(posedge clk) begin
        if (rst) begin
            alt_q <= 1'b0;
            max_q <= '0;
        end else if (launch) begin
            alt_q <= use_alt_bit;
            max_q <= max_pairs;
        end
    end

    toggle_sampler u_sampler (
        .clk       (clk),
        .rst       (rst),
        .capture   (capture),
        .use_alt   (alt_q),
        .rdata     (bus_rdata),
        .toggled   (toggled),
        .fail_flag (fail_flag)
    );

    pair_limit #(.CNT_W(CNT_W)) u_limit (
        .clk       (clk),
        .rst       (rst),
        .clr       (launch),
        .inc       (cnt_inc),
        .max_pairs (max_q),
        .limit_hit (limit_hit)
    );

    poll_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .abort     (abort),
        .bus_ack   (bus_ack),
        .toggled   (toggled),
        .fail_flag (fail_flag),
        .limit_hit (limit_hit),
        .cmd       (cmd),
        .capture   (capture),
        .launch    (launch),
        .cnt_inc   (cnt_inc),
        .busy      (busy),
        .done      (done),
        .result    (result)
    );

    assign bus_req   = cmd.req;
    assign bus_we    = cmd.we;
    assign bus_wdata = cmd.wdata;
    assign fail      = result.fail;
    assign timeout   = result.timeout;

    // R1: the cycle after reset everything is quiet
    a_r1_reset_quiet: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!busy && !done && !bus_req && !fail && !timeout));

endmodule

// File: tb/tb_toggle_status_poller.sv
module tb_toggle_status_poller;

    localparam int CNT_W = 4;

    typedef struct packed {
        logic [47:0] rd;    // byte k of the read stream at bits [8k+7:8k]
        logic [2:0]  nrd;
        logic        alt;
        logic [3:0]  maxp;
        logic        efail;
        logic        etmo;
        logic [2:0]  erd;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{rd: 48'h0000_0000_4040, nrd: 3'd2, alt: 1'b0, maxp: 4'd4, efail: 1'b0, etmo: 1'b0, erd: 3'd2},
        '{rd: 48'h0000_0000_0040, nrd: 3'd4, alt: 1'b0, maxp: 4'd4, efail: 1'b0, etmo: 1'b0, erd: 3'd4},
        '{rd: 48'h0000_2020_2040, nrd: 3'd4, alt: 1'b0, maxp: 4'd4, efail: 1'b0, etmo: 1'b0, erd: 3'd4},
        '{rd: 48'h0000_2040_2040, nrd: 3'd4, alt: 1'b0, maxp: 4'd4, efail: 1'b1, etmo: 1'b0, erd: 3'd4},
        '{rd: 48'h0000_0040_0040, nrd: 3'd4, alt: 1'b0, maxp: 4'd2, efail: 1'b1, etmo: 1'b1, erd: 3'd4},
        '{rd: 48'h0000_4040_4044, nrd: 3'd4, alt: 1'b1, maxp: 4'd4, efail: 1'b0, etmo: 1'b0, erd: 3'd4},
        '{rd: 48'h0000_0000_0444, nrd: 3'd2, alt: 1'b1, maxp: 4'd4, efail: 1'b0, etmo: 1'b0, erd: 3'd2},
        '{rd: 48'h0000_0000_0060, nrd: 3'd4, alt: 1'b0, maxp: 4'd4, efail: 1'b0, etmo: 1'b0, erd: 3'd4},
        '{rd: 48'h0000_0000_0040, nrd: 3'd2, alt: 1'b0, maxp: 4'd0, efail: 1'b1, etmo: 1'b1, erd: 3'd2},
        '{rd: 48'h0000_0000_2040, nrd: 3'd4, alt: 1'b0, maxp: 4'd1, efail: 1'b0, etmo: 1'b0, erd: 3'd4},
        '{rd: 48'h0040_0040_0040, nrd: 3'd6, alt: 1'b0, maxp: 4'd3, efail: 1'b1, etmo: 1'b1, erd: 3'd6},
        '{rd: 48'h0000_0040_2040, nrd: 3'd4, alt: 1'b0, maxp: 4'd4, efail: 1'b1, etmo: 1'b0, erd: 3'd4}
    };
    string vtag [NV] = '{
        "R3 stable first pair", "R4 toggle then stable", "R5 recheck stops", "R6 recheck still toggles",
        "R8 cap of two", "R7 alt bit toggles", "R7 alt bit steady", "R4 first-read flag ignored",
        "R8 zero cap acts as one", "R8 recheck pair not counted", "R8 cap of three", "R6 recheck flag clear"
    };

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             start = 1'b0;
    logic             abort = 1'b0;
    logic             use_alt_bit = 1'b0;
    logic [CNT_W-1:0] max_pairs = '0;
    logic             bus_ack = 1'b0;
    logic [7:0]       bus_rdata = 8'h00;
    logic             bus_req, bus_we, busy, done, fail, timeout;
    logic [7:0]       bus_wdata;

    int n_chk = 0;
    int n_err = 0;

    always #2.5 clk = ~clk;

    toggle_status_poller #(.CNT_W(CNT_W)) dut (
        .clk(clk), .rst(rst), .start(start), .abort(abort),
        .use_alt_bit(use_alt_bit), .max_pairs(max_pairs),
        .bus_req(bus_req), .bus_we(bus_we), .bus_wdata(bus_wdata),
        .bus_ack(bus_ack), .bus_rdata(bus_rdata),
        .busy(busy), .done(done), .fail(fail), .timeout(timeout)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Runs one polling attempt, acting as the flash on the bus.
    // abort_at: abort when this many reads have been served (-1: never).
    // glitch_at: pulse start again right after this many reads (-1: never).
    task automatic run(input vec_t v, input string tag, input int abort_at,
                       input int glitch_at, input int wr_delay);
        int  nreads = 0;
        int  nwr = 0;
        int  wval = 0;
        int  wd = 0;
        int  cyc = 0;
        bit  got_done = 0;
        bit  ack_prev = 0;
        bit  aborted = 0;
        int  got_fail = 0;
        int  got_tmo = 0;
        use_alt_bit = v.alt;
        max_pairs   = v.maxp;
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk({tag, " R11 outcome cleared at start"}, int'(fail) + int'(timeout), 0);
        chk({tag, " R2 busy after start"}, int'(busy), 1);
        while (!got_done && !aborted && cyc < 300) begin
            bus_ack = 1'b0;
            start   = 1'b0;
            if (done) begin
                got_done = 1;
                got_fail = int'(fail);
                got_tmo  = int'(timeout);
                chk({tag, " R3 busy low with done"}, int'(busy), 0);
            end else if (bus_req && !ack_prev) begin
                if (bus_we) begin
                    if (wd < wr_delay) begin
                        wd++;
                        chk({tag, " R9 busy held before write ack"}, int'(busy), 1);
                    end else begin
                        bus_ack = 1'b1;
                        nwr++;
                        wval = int'(bus_wdata);
                    end
                end else if (nreads == abort_at) begin
                    abort = 1'b1;
                    aborted = 1;
                end else begin
                    bus_rdata = (nreads < int'(v.nrd)) ? v.rd[nreads*8 +: 8] : 8'h00;
                    bus_ack = 1'b1;
                    nreads++;
                    if (nreads == glitch_at) start = 1'b1;
                end
            end
            ack_prev = bus_ack;
            if (!got_done) @(negedge clk);
            cyc++;
        end
        bus_ack = 1'b0;
        start   = 1'b0;
        if (aborted) begin
            abort = 1'b0;
            chk({tag, " R10 busy low after abort"}, int'(busy), 0);
            chk({tag, " R10 no done on abort"}, int'(done), 0);
            chk({tag, " R10 request dropped"}, int'(bus_req), 0);
            chk({tag, " R10 reads before abort"}, nreads, abort_at);
        end else begin
            chk({tag, " R3 done seen"}, int'(got_done), 1);
            chk({tag, " fail"}, got_fail, int'(v.efail));
            chk({tag, " R8 timeout"}, got_tmo, int'(v.etmo));
            chk({tag, " R2 read count"}, nreads, int'(v.erd));
            chk({tag, " R9 write count"}, nwr, int'(v.efail));
            if (v.efail) chk({tag, " R9 write data"}, wval, 32'hF0);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_err++;
        $display("FAIL R2 watchdog expired: actual hung expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
        $finish;
    end

    initial begin
        vec_t d;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 busy after reset", int'(busy), 0);
        chk("R1 done after reset", int'(done), 0);
        chk("R1 fail after reset", int'(fail), 0);
        chk("R1 timeout after reset", int'(timeout), 0);
        chk("R1 bus_req after reset", int'(bus_req), 0);

        for (int i = 0; i < NV; i++) begin
            run(VECS[i], vtag[i], -1, -1, 0);
        end

        // R11: a failed outcome is held after done
        repeat (4) @(negedge clk);
        chk("R11 fail held", int'(fail), 1);
        chk("R11 done not repeated", int'(done), 0);

        // R9: delayed acknowledge of the reset write
        run(VECS[3], "R9 delayed write ack", -1, -1, 3);

        // R2: start while busy is ignored
        run(VECS[1], "R2 start while busy", -1, 1, 0);
        run(VECS[3], "R2 start while busy on fail", -1, 3, 0);

        // R10: abort after the recheck decision, then a fresh start
        d = '{rd: 48'h0000_0000_2040, nrd: 3'd2, alt: 1'b0, maxp: 4'd4, efail: 1'b0, etmo: 1'b0, erd: 3'd2};
        run(d, "R10 abort in recheck", 2, -1, 0);
        d = '{rd: 48'h0000_4040_2040, nrd: 3'd4, alt: 1'b0, maxp: 4'd4, efail: 1'b0, etmo: 1'b0, erd: 3'd4};
        run(d, "R10 fresh recheck after abort", -1, -1, 0);

        // R10: abort after two counted pairs, then the count starts from zero
        d = '{rd: 48'h0000_0040_0040, nrd: 3'd4, alt: 1'b0, maxp: 4'd3, efail: 1'b0, etmo: 1'b0, erd: 3'd4};
        run(d, "R10 abort after counted pairs", 4, -1, 0);
        d = '{rd: 48'h0000_0040_0040, nrd: 3'd6, alt: 1'b0, maxp: 4'd3, efail: 1'b0, etmo: 1'b0, erd: 3'd6};
        run(d, "R10 fresh count after abort", -1, -1, 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
        $finish;
    end

endmodule